// File: doc/BRIEF.md
# MDIO Management Master

This block runs Clause 22 management transactions towards an external PHY on the two-wire management bus. A processor reaches it through a small register port with four word registers: configuration, command, write data and read data. The block derives the management clock from the system clock, shifts out the full management frame and releases the data line for the turnaround and data fields of a read. It captures the 16 bits the PHY returns and reports through a single ready bit when a new command may be issued.

Software first writes the configuration register with a clock divisor and the enable bit. The management clock runs at the system clock divided by 2*(1+divisor). For a bus limited to 2.5 MHz, software picks the smallest divisor that keeps the clock at or under that limit, rounding up on any remainder. For a write, the data word is loaded first and the command word with its start bit follows. For a read, software waits for ready and then fetches the read-data register. The data line is split into a driven value, an output enable and a sampled input, so the pad tristate sits outside the block.

Top module: `mdio_master`

## Requirements
- R1: After reset the enable bit is clear, the divisor reads as DIV_RESET (default 24), `mdc` is low, `mdio_oe` is low and the ready bit reads 0. Register map: address 0 is configuration (divisor in bits [DIV_W-1:0], enable in bit 31). Address 1 is command (register address [4:0], PHY address [12:8], operation [17:16], start bit 20, read-only ready bit 31). Address 2 is write data [15:0]. Address 3 is read data [15:0].
- R2: The ready bit is 1 exactly when the block is enabled and no transaction is running. It reads 1 in the cycle after the enable bit is written with 1. `mdio_oe` is low whenever ready is 1.
- R3: During a transaction, each MDC period lasts 2*(div+1) system clocks, where div is the divisor sampled when the command was accepted. Later writes to the divisor do not affect the transaction in flight. MDC is low whenever no transaction runs.
- R4: Every frame is 64 MDC bits, most significant bit first: 32 ones, start pattern 01, the operation code (01 write, 10 read, equal to the command's operation field), the 5-bit PHY address and then the 5-bit register address.
- R5: A write frame drives the turnaround as 10 and then sends the 16-bit write-data value, with `mdio_oe` high for all 64 bits.
- R6: A read frame holds `mdio_oe` low for the last 18 bits and samples `mdio_i` on the rising MDC edge of each of the last 16 bits. The result appears in read-data bits [15:0], and bits [31:16] read as zero.
- R7: `mdio_o` and `mdio_oe` change only at the falling MDC edge (or at the start or end of a frame), never while MDC stays high.
- R8: A start bit written while ready is 0, whether the block is disabled or busy, is ignored. No frame starts and the command fields read back unchanged.
- R9: A start bit written with operation 00 or 11 is ignored, even when ready is 1.
- R10: Ready reads 0 from the cycle after an accepted start until the falling MDC edge that ends bit 64. After that, the command register reads back the accepted PHY address, register address and operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select for reads and writes |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Read value of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data value to drive |
| mdio_oe | output | 1 | Output enable for the management data pad |
| mdio_i | input | 1 | Management data sampled from the pad |

## Verification
The assertions check four things on every cycle. They check the MDC high-phase length against the latched divisor, and that MDC stays low and the line stays released while idle. They check that the data line holds still while MDC is high and that the upper read-data bits stay zero. They also check that a start request is dropped while disabled or with a reserved operation code. Only the bench's PHY model can show that whole frames carry the right bit sequence and turnaround release, and that returned data lands in the read-data register. The same holds for commands issued during a busy frame and for divisor writes in mid-frame, which leave the frame in flight untouched.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS      = 32;
    localparam int FRAME_BITS    = PRE_BITS + 32;
    localparam int IDX_W         = $clog2(FRAME_BITS);
    localparam int TA_FIRST      = FRAME_BITS - 18;
    localparam int RD_DATA_FIRST = FRAME_BITS - 16;

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_CMD  = 2'd1;
    localparam logic [1:0] ADDR_WDAT = 2'd2;
    localparam logic [1:0] ADDR_RDAT = 2'd3;

    localparam int CFG_EN_BIT    = 31;
    localparam int CMD_START_BIT = 20;
    localparam int CMD_READY_BIT = 31;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RSVD  = 2'b11
    } mdio_op_e;

    typedef struct packed {
        logic [4:0] phy;
        logic [4:0] regad;
        mdio_op_e   op;
    } mdio_cmd_t;

    function automatic logic op_valid(mdio_op_e op);
        return (op == OP_WRITE) || (op == OP_READ);
    endfunction

    function automatic mdio_cmd_t decode_cmd(logic [31:0] w);
        mdio_cmd_t c;
        c.regad = w[4:0];
        c.phy   = w[12:8];
        c.op    = mdio_op_e'(w[17:16]);
        return c;
    endfunction

    // Full serial frame, first bit on the wire in the MSB.
    function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c, logic [15:0] d);
        logic [1:0]  ta;
        logic [15:0] body;
        ta   = (c.op == OP_READ) ? 2'b11 : 2'b10;
        body = (c.op == OP_READ) ? 16'hFFFF : d;
        return {{PRE_BITS{1'b1}}, 2'b01, c.op, c.phy, c.regad, ta, body};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic             mdc_q;
    logic             wrap;

    assign wrap = (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign mdc       = mdc_q;
    assign rise_tick = run && wrap && !mdc_q;
    assign fall_tick = run && wrap && mdc_q;

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  mdio_cmd_t        cmd,
    input  logic [15:0]      wdata,
    input  logic [DIV_W-1:0] div_in,
    input  logic             rise_tick,
    input  logic             fall_tick,
    input  logic             mdio_i,
    output logic             busy,
    output logic [DIV_W-1:0] div_q,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic [15:0]      rx_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_FIRST);
    localparam logic [IDX_W-1:0] RD_IDX   = IDX_W'(RD_DATA_FIRST);

    logic                  busy_q;
    logic                  is_rd;
    logic [IDX_W-1:0]      idx;
    logic [FRAME_BITS-1:0] tx;
    logic [15:0]           rx_sh;
    logic [15:0]           rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            is_rd  <= 1'b0;
            idx    <= '0;
            tx     <= '1;
            rx_sh  <= '0;
            rx_q   <= '0;
            div_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            is_rd  <= (cmd.op == OP_READ);
            idx    <= '0;
            tx     <= build_frame(cmd, wdata);
            div_q  <= div_in;
        end else if (busy_q) begin
            if (rise_tick && is_rd && (idx >= RD_IDX)) begin
                rx_sh <= {rx_sh[14:0], mdio_i};
            end
            if (fall_tick) begin
                if (idx == LAST_IDX) begin
                    busy_q <= 1'b0;
                    if (is_rd) begin
                        rx_q <= rx_sh;
                    end
                end else begin
                    idx <= idx + 1'b1;
                    tx  <= {tx[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end

    assign busy    = busy_q;
    assign mdio_o  = busy_q ? tx[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = busy_q && !(is_rd && (idx >= TA_IDX));
    assign rx_data = rx_q;

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       reg_addr,
    input  logic             reg_we,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             busy,
    input  logic [15:0]      rx_data,
    output logic [DIV_W-1:0] cfg_div,
    output logic             cfg_en,
    output logic             start,
    output mdio_cmd_t        cmd,
    output logic [15:0]      wdata,
    output logic             ready
);
    mdio_cmd_t new_cmd;
    logic      start_req;

    assign ready     = cfg_en && !busy;
    assign new_cmd   = decode_cmd(reg_wdata);
    assign start_req = reg_we && (reg_addr == ADDR_CMD) && reg_wdata[CMD_START_BIT];
    assign start     = start_req && ready && op_valid(new_cmd.op);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_div <= DIV_W'(DIV_RESET);
            cfg_en  <= 1'b0;
            cmd     <= '0;
            wdata   <= '0;
        end else begin
            if (reg_we && (reg_addr == ADDR_CFG)) begin
                cfg_div <= reg_wdata[DIV_W-1:0];
                cfg_en  <= reg_wdata[CFG_EN_BIT];
            end
            if (reg_we && (reg_addr == ADDR_WDAT)) begin
                wdata <= reg_wdata[15:0];
            end
            if (start) begin
                cmd <= new_cmd;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CFG: begin
                reg_rdata[DIV_W-1:0]  = cfg_div;
                reg_rdata[CFG_EN_BIT] = cfg_en;
            end
            ADDR_CMD: begin
                reg_rdata[4:0]           = cmd.regad;
                reg_rdata[12:8]          = cmd.phy;
                reg_rdata[17:16]         = cmd.op;
                reg_rdata[CMD_READY_BIT] = ready;
            end
            ADDR_WDAT: reg_rdata[15:0] = wdata;
            default:   reg_rdata[15:0] = rx_data;
        endcase
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  reg_addr,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [DIV_W-1:0] cfg_div;
    logic [DIV_W-1:0] div_q;
    logic             cfg_en;
    logic             start;
    logic             busy;
    logic             ready;
    logic             rise_tick;
    logic             fall_tick;
    logic [15:0]      wdata;
    logic [15:0]      rx_data;
    mdio_cmd_t        cmd;

    mdio_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .rx_data   (rx_data),
        .cfg_div   (cfg_div),
        .cfg_en    (cfg_en),
        .start     (start),
        .cmd       (cmd),
        .wdata     (wdata),
        .ready     (ready)
    );

    mdio_frame_seq #(.DIV_W(DIV_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd       (decode_cmd(reg_wdata)),
        .wdata     (wdata),
        .div_in    (cfg_div),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .div_q     (div_q),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rx_data   (rx_data)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .div       (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       reg_addr,
    input logic             reg_we,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             busy,
    input logic             ready,
    input logic             cfg_en,
    input logic [DIV_W-1:0] div_q
);
    logic        prev_mdc;
    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_mdc <= 1'b0;
            run_len  <= '0;
        end else begin
            prev_mdc <= mdc;
            run_len  <= (mdc != prev_mdc) ? 32'd1 : run_len + 32'd1;
        end
    end

    p_mdc_low_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    p_half_period_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(mdc) |-> (run_len == 32'(div_q) + 32'd1));

    p_ready_released_r2: assert property (@(posedge clk) disable iff (rst)
        ready |-> !mdio_oe);

    p_stable_high_r7: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    p_rdata_upper_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd3) |-> (reg_rdata[31:16] == 16'h0000));

    p_disabled_start_r8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !busy && reg_we && reg_addr == 2'd1 && reg_wdata[20]) |=> !busy);

    p_bad_op_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && reg_we && reg_addr == 2'd1 &&
         (reg_wdata[17:16] == 2'b00 || reg_wdata[17:16] == 2'b11)) |=> !busy);

endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (busy),
    .ready     (ready),
    .cfg_en    (cfg_en),
    .div_q     (div_q)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;

    localparam int DIV_W     = 8;
    localparam int DIV_RESET = 24;
    localparam real TCLK     = 5.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    mdio_master #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) i_mdio_master (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model
    int          cap_cnt = 0;
    logic [63:0] cap_o, cap_oe;
    logic [15:0] phy_resp = 16'h0;
    realtime     last_rise = 0.0;
    real         exp_period = 10.0;
    int          per_err = 0;
    int          r7_err = 0;
    logic        pm_mdc = 1'b0, pm_o = 1'b1, pm_oe = 1'b0;

    always @(posedge mdc) begin
        cap_o  = {cap_o[62:0], mdio_o};
        cap_oe = {cap_oe[62:0], mdio_oe};
        if (cap_cnt > 0) begin
            if (($realtime - last_rise) > exp_period + 0.1 ||
                ($realtime - last_rise) < exp_period - 0.1) per_err++;
        end
        last_rise = $realtime;
        cap_cnt++;
    end

    always @(negedge mdc) begin
        if (cap_cnt >= 48 && cap_cnt < 64) mdio_i = phy_resp[63 - cap_cnt];
        else mdio_i = 1'b1;
    end

    always @(negedge clk) begin
        if (!rst && mdc && pm_mdc && (mdio_o !== pm_o || mdio_oe !== pm_oe)) r7_err++;
        pm_mdc = mdc; pm_o = mdio_o; pm_oe = mdio_oe;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] cmd_word(input logic [1:0] op, input logic [4:0] phy,
                                             input logic [4:0] ra, input bit st);
        return (32'(st) << 20) | (32'(op) << 16) | (32'(phy) << 8) | 32'(ra);
    endfunction

    function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] phy,
                                              input logic [4:0] ra, input logic [15:0] d);
        logic [63:0] f;
        f[63:32] = 32'hFFFF_FFFF;
        f[31:30] = 2'b01;
        f[29:28] = op;
        f[27:23] = phy;
        f[22:18] = ra;
        f[17:16] = (op == 2'b10) ? 2'b00 : 2'b10;
        f[15:0]  = (op == 2'b10) ? 16'h0 : d;
        return f;
    endfunction

    task automatic wait_ready();
        logic [31:0] v;
        for (int i = 0; i < 40000; i++) begin
            rd(2'd1, v);
            if (v[31]) return;
        end
        check(1'b0, "R10 ready never returned", 64'(v), 64'h8000_0000);
    endtask

    logic [1:0]  t_op;
    logic [4:0]  t_phy, t_reg;
    logic [15:0] t_data, t_resp;

    task automatic begin_txn(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] d, input logic [15:0] resp, input int div);
        logic [31:0] v;
        t_op = op; t_phy = phy; t_reg = ra; t_data = d; t_resp = resp;
        wr(2'd0, 32'h8000_0000 | 32'(div));
        exp_period = 2.0 * (div + 1) * TCLK;
        per_err = 0; r7_err = 0; cap_cnt = 0; phy_resp = resp;
        wr(2'd2, {16'h0, d});
        wr(2'd1, cmd_word(op, phy, ra, 1'b1));
        rd(2'd1, v);
        check(v[31] == 1'b0, "R10 ready low during frame", 64'(v[31]), 64'd0);
    endtask

    task automatic finish_txn();
        logic [63:0] mask;
        logic [31:0] v;
        wait_ready();
        mask = (t_op == 2'b10) ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
        check(cap_cnt == 64, "R4 frame bit count", 64'(cap_cnt), 64'd64);
        check((cap_o & mask) == (exp_frame(t_op, t_phy, t_reg, t_data) & mask),
              (t_op == 2'b10) ? "R4 read frame header" : "R5 write frame content",
              cap_o & mask, exp_frame(t_op, t_phy, t_reg, t_data) & mask);
        check(cap_oe == mask, "R6 output enable pattern", cap_oe, mask);
        check(per_err == 0, "R3 MDC period", 64'(per_err), 64'd0);
        check(r7_err == 0, "R7 data change while MDC high", 64'(r7_err), 64'd0);
        if (t_op == 2'b10) begin
            rd(2'd3, v);
            check(v == {16'h0, t_resp}, "R6 read data capture", 64'(v), {48'h0, t_resp});
        end
        rd(2'd1, v);
        check(v[17:0] == {t_op, 3'b000, t_phy, 3'b000, t_reg}, "R10 command readback",
              64'(v[17:0]), 64'({t_op, 3'b000, t_phy, 3'b000, t_reg}));
    endtask

    initial begin
        #(150000 * TCLK);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 mdc/oe after reset", {mdc, mdio_oe}, 64'd0);
        rd(2'd0, v);
        check(v == 32'(DIV_RESET), "R1 config reset value", 64'(v), 64'(DIV_RESET));
        rd(2'd1, v);
        check(v[31] == 1'b0, "R1 ready low after reset", 64'(v[31]), 64'd0);

        // R8 start while disabled
        cap_cnt = 0;
        wr(2'd1, cmd_word(2'b10, 5'd3, 5'd2, 1'b1));
        repeat (60) @(negedge clk);
        check(cap_cnt == 0 && mdc == 1'b0, "R8 start ignored while disabled", 64'(cap_cnt), 64'd0);
        rd(2'd1, v);
        check(v == 32'h0, "R8 command unchanged while disabled", 64'(v), 64'd0);

        // R2 enable raises ready
        wr(2'd0, 32'h8000_0002);
        rd(2'd1, v);
        check(v[31] == 1'b1, "R2 ready after enable", 64'(v[31]), 64'd1);
        check(mdio_oe == 1'b0, "R2 line released when ready", 64'(mdio_oe), 64'd0);

        // R9 reserved operation codes
        wr(2'd1, cmd_word(2'b00, 5'd1, 5'd1, 1'b1));
        repeat (40) @(negedge clk);
        check(cap_cnt == 0, "R9 op 00 ignored", 64'(cap_cnt), 64'd0);
        wr(2'd1, cmd_word(2'b11, 5'd1, 5'd1, 1'b1));
        repeat (40) @(negedge clk);
        check(cap_cnt == 0, "R9 op 11 ignored", 64'(cap_cnt), 64'd0);
        rd(2'd1, v);
        check(v == 32'h8000_0000, "R9 ready and fields unchanged", 64'(v), 64'h8000_0000);

        // Directed frames
        begin_txn(2'b01, 5'd5, 5'd9, 16'hBEEF, 16'h0, 0);   finish_txn();
        begin_txn(2'b10, 5'd2, 5'd1, 16'h0, 16'hA5C3, 3);   finish_txn();
        begin_txn(2'b01, 5'd31, 5'd31, 16'hFFFF, 16'h0, 1); finish_txn();
        begin_txn(2'b10, 5'd0, 5'd0, 16'h0, 16'h0001, 2);   finish_txn();

        // R8 command during a busy frame is dropped
        begin_txn(2'b10, 5'd1, 5'd4, 16'h0, 16'h3C5A, 1);
        repeat (20) @(negedge clk);
        wr(2'd1, cmd_word(2'b01, 5'd7, 5'd7, 1'b1));
        finish_txn();
        repeat (300) @(negedge clk);
        check(cap_cnt == 64, "R8 no second frame after busy start", 64'(cap_cnt), 64'd64);

        // R3 divisor latched at start
        begin_txn(2'b01, 5'd9, 5'd3, 16'h1234, 16'h0, 2);
        repeat (30) @(negedge clk);
        wr(2'd0, 32'h8000_0000);
        finish_txn();

        // Random frames
        for (int n = 0; n < 10; n++) begin
            logic [1:0] op;
            op = ($urandom() & 1) ? 2'b10 : 2'b01;
            begin_txn(op, 5'($urandom()), 5'($urandom()), 16'($urandom()),
                      16'($urandom()), int'($urandom() % 4));
            finish_txn();
        end

        rd(2'd3, v);
        check(v[31:16] == 16'h0, "R6 read data upper bits", 64'(v[31:16]), 64'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule